// File: doc/BRIEF.md
# Quad-Phase System Clock Generator

This block turns a fast master clock into the two slow system clocks that pace a four-phase machine cycle. Each rising edge of the master clock counts as one tick. A machine cycle lasts n ticks. Clock A is high for the first half of the cycle and low for the second half. A second clock, /B, runs at twice the rate of A. It is built from a double-rate reference that is delayed by one tick and then inverted. Because of that one-tick delay, the edges of /B never line up with the edges of A, and the two levels together mark out four phases in every cycle.

A 2-bit select input sets n to one of three cycle lengths: 18, 14 or 12 ticks. The block samples the select only when a cycle ends, so a change never produces a short or stretched cycle. The block also outputs the current phase as a 2-bit code, and a one-tick strobe on the first tick of each new cycle. A synchronous reset restarts the sequence from the first tick of a cycle.

Top module: `quad_phase_clkgen`

## Requirements
- R1: A cycle lasts n ticks, where the select code gives n: 2'b00 gives 18, 2'b01 gives 14, 2'b10 gives 12, and 2'b11 falls back to 18. Within a cycle the tick index k runs from 0 to n-1 and then returns to 0.
- R2: Output A is 1 when k < n/2 and 0 for the remaining n/2 ticks of the cycle.
- R3: A double-rate reference is 1 for the first floor(n/4) ticks of each half of A and 0 for the rest of that half. For n = 18 this is 4 ticks high and 5 ticks low.
- R4: Output /B equals the inverse of the R3 reference as it was one tick earlier. In the first tick of a cycle, that earlier tick is the last tick of the previous cycle. For n = 18, /B is 0 at k = 1..4 and k = 10..13, and 1 at every other k.
- R5: The select input is sampled only on the tick that moves k from n-1 to 0. Changing the select at any other tick has no effect on the cycle that is running.
- R6: The phase output equals {~A, ~/B}:
  - 0 when A = 1 and /B = 1
  - 1 when A = 1 and /B = 0
  - 2 when A = 0 and /B = 1
  - 3 when A = 0 and /B = 0
- R7: The cycle strobe is 1 during exactly those ticks where k has just wrapped from n-1 to 0. It is never 1 for two ticks in a row.
- R8: While reset is high at a clock edge, the block sets k to 0 and loads the select. Its outputs then read A = 1, /B = 1, phase = 0 and strobe = 0. Counting resumes from k = 0 after release, and the first tick after release is k = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master tick clock |
| rst | input | 1 | Synchronous reset, active high |
| len_sel | input | 2 | Cycle-length select (00: 18, 01: 14, 10: 12, 11: 18) |
| a_clk | output | 1 | System clock A, registered |
| b_clk_n | output | 1 | System clock /B (inverted double-rate clock, one tick late), registered |
| phase | output | 2 | Current phase code {~A, ~/B} |
| cyc_start | output | 1 | One-tick strobe on the first tick of each cycle |

## Verification
The assertions assume three things about the inputs:
- The master clock runs freely.
- Reset is sampled only at clock edges.
- The select may take any of its four codes at any time, because the design latches it at the cycle boundary.

The properties also assume that the output registers start from their reset values. For that reason the stimulus holds reset high from time zero for several ticks. The bench changes the select and reset only at falling clock edges. It switches the select both in the middle of a cycle and on the exact tick before a wrap. This keeps every input change one half-period away from the edge that samples it.

// File: rtl/qpc_pkg.sv
package qpc_pkg;

  typedef enum logic [1:0] {
    SEL_LONG  = 2'b00,
    SEL_MID   = 2'b01,
    SEL_SHORT = 2'b10,
    SEL_SPARE = 2'b11
  } len_sel_e;

  function automatic int max_of3(input int x, input int y, input int z);
    int m;
    m = x;
    if (y > m) m = y;
    if (z > m) m = z;
    return m;
  endfunction

endpackage

// File: rtl/qpc_len_decode.sv
module qpc_len_decode
  import qpc_pkg::*;
#(
  parameter int N_LONG  = 18,
  parameter int N_MID   = 14,
  parameter int N_SHORT = 12,
  parameter int W       = 5
) (
  input  logic [1:0]   sel,
  output logic [W-1:0] len
);

  always_comb begin
    unique case (len_sel_e'(sel))
      SEL_MID:   len = W'(N_MID);
      SEL_SHORT: len = W'(N_SHORT);
      default:   len = W'(N_LONG);
    endcase
  end

endmodule

// File: rtl/qpc_tick_counter.sv
module qpc_tick_counter #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] len_req,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cnt_nx,
  output logic [W-1:0] len_cur,
  output logic [W-1:0] len_nx,
  output logic         wrap_nx
);

  always_comb begin
    wrap_nx = (cnt == (len_cur - W'(1)));
    cnt_nx  = wrap_nx ? '0 : (cnt + W'(1));
    len_nx  = wrap_nx ? len_req : len_cur;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      len_cur <= len_req;
    end else begin
      cnt     <= cnt_nx;
      len_cur <= len_nx;
    end
  end

endmodule

// File: rtl/qpc_wave.sv
module qpc_wave #(
  parameter int W = 5
) (
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] len,
  output logic         a_lvl,
  output logic         d_lvl
);

  logic [W-1:0] half_len;
  logic [W-1:0] quarter_len;
  logic [W-1:0] pos_in_half;

  always_comb begin
    half_len    = len >> 1;
    quarter_len = len >> 2;
    a_lvl       = (cnt < half_len);
    pos_in_half = a_lvl ? cnt : (cnt - half_len);
    d_lvl       = (pos_in_half < quarter_len);
  end

endmodule

// File: rtl/quad_phase_clkgen.sv
module quad_phase_clkgen
  import qpc_pkg::*;
#(
  parameter int N_LONG  = 18,
  parameter int N_MID   = 14,
  parameter int N_SHORT = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] len_sel,
  output logic       a_clk,
  output logic       b_clk_n,
  output logic [1:0] phase,
  output logic       cyc_start
);

  localparam int N_MAX = max_of3(N_LONG, N_MID, N_SHORT);
  localparam int W     = $clog2(N_MAX + 1);

  logic [W-1:0] len_req;
  logic [W-1:0] cnt_w;
  logic [W-1:0] cnt_nx_w;
  logic [W-1:0] len_cur_w;
  logic [W-1:0] len_nx_w;
  logic         wrap_nx_w;

  logic         a_next;
  logic         d_next_unused;
  logic         a_now_unused;
  logic         d_now;

  qpc_len_decode #(
    .N_LONG (N_LONG),
    .N_MID  (N_MID),
    .N_SHORT(N_SHORT),
    .W      (W)
  ) u_dec (
    .sel(len_sel),
    .len(len_req)
  );

  qpc_tick_counter #(.W(W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .len_req(len_req),
    .cnt    (cnt_w),
    .cnt_nx (cnt_nx_w),
    .len_cur(len_cur_w),
    .len_nx (len_nx_w),
    .wrap_nx(wrap_nx_w)
  );

  // Levels for the tick about to start: these drive A.
  qpc_wave #(.W(W)) u_wave_next (
    .cnt  (cnt_nx_w),
    .len  (len_nx_w),
    .a_lvl(a_next),
    .d_lvl(d_next_unused)
  );

  // Levels for the tick now ending: the reference one tick late forms /B.
  qpc_wave #(.W(W)) u_wave_now (
    .cnt  (cnt_w),
    .len  (len_cur_w),
    .a_lvl(a_now_unused),
    .d_lvl(d_now)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_clk     <= 1'b1;
      b_clk_n   <= 1'b1;
      phase     <= 2'd0;
      cyc_start <= 1'b0;
    end else begin
      a_clk     <= a_next;
      b_clk_n   <= ~d_now;
      phase     <= {~a_next, d_now};
      cyc_start <= wrap_nx_w;
    end
  end

endmodule

// File: rtl/qpc_chk.sv
module qpc_chk #(
  parameter int W = 5
) (
  input logic         clk,
  input logic         rst,
  input logic         a_clk,
  input logic         b_clk_n,
  input logic [1:0]   phase,
  input logic         cyc_start,
  input logic [W-1:0] cnt,
  input logic [W-1:0] len_cur
);

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt < len_cur) else $error("count beyond cycle length"); // R1

  AST_A_RISE_AT_START: assert property (@(posedge clk) disable iff (rst)
    $rose(a_clk) |-> cyc_start) else $error("A rose off cycle start"); // R2

  AST_EDGES_APART: assert property (@(posedge clk) disable iff (rst)
    !$stable(a_clk) |-> $stable(b_clk_n)) else $error("A and /B moved together"); // R4

  AST_PHASE_CODE: assert property (@(posedge clk) disable iff (rst)
    phase == {~a_clk, ~b_clk_n}) else $error("phase code mismatch"); // R6

  AST_START_PHASE0: assert property (@(posedge clk) disable iff (rst)
    cyc_start |-> (a_clk && phase == 2'd0)) else $error("strobe outside phase 0"); // R7

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
    cyc_start |=> !cyc_start) else $error("strobe longer than one tick"); // R7

  AST_START_WRAP: assert property (@(posedge clk) disable iff (rst)
    cyc_start |-> cnt == '0) else $error("strobe without wrap"); // R7

endmodule

bind quad_phase_clkgen qpc_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .a_clk    (a_clk),
  .b_clk_n  (b_clk_n),
  .phase    (phase),
  .cyc_start(cyc_start),
  .cnt      (cnt_w),
  .len_cur  (len_cur_w)
);

// File: tb/quad_phase_clkgen_tb.sv
module quad_phase_clkgen_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] len_sel = 2'b00;
  logic       a_clk;
  logic       b_clk_n;
  logic [1:0] phase;
  logic       cyc_start;

  int n_checks = 0;
  int n_bad    = 0;
  bit done     = 1'b0;

  // reference model state
  int  mk = 0;
  int  mn = 18;
  bit  eb = 1'b1;
  bit  es = 1'b0;
  int  strobes = 0;

  always #5 clk = ~clk;

  quad_phase_clkgen u_dut (
    .clk      (clk),
    .rst      (rst),
    .len_sel  (len_sel),
    .a_clk    (a_clk),
    .b_clk_n  (b_clk_n),
    .phase    (phase),
    .cyc_start(cyc_start)
  );

  function automatic int sel_len(input logic [1:0] s);
    case (s)
      2'b01:   return 14;
      2'b10:   return 12;
      default: return 18;
    endcase
  endfunction

  function automatic bit ref_d(input int k, input int n);
    int h;
    int p;
    h = n / 2;
    p = (k < h) ? k : k - h;
    return p < (n / 4);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mk = 0;
      mn = sel_len(len_sel);
      eb = 1'b1;
      es = 1'b0;
    end else begin
      eb = ~ref_d(mk, mn);
      es = (mk == mn - 1);
      if (es) begin
        mk = 0;
        mn = sel_len(len_sel);
        strobes++;
      end else begin
        mk++;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d (k=%0d n=%0d t=%0t)", tag, act, exp, mk, mn, $time);
    end
  endtask

  task automatic check_tick();
    bit ea;
    ea = (mk < mn / 2);
    check(a_clk == ea, "R1/R2 A level", a_clk, ea);
    check(b_clk_n == eb, "R3/R4 /B level", b_clk_n, eb);
    check(phase == {~ea, ~eb}, "R6 phase", phase, {~ea, ~eb});
    check(cyc_start == es, "R7 strobe", cyc_start, es);
  endtask

  task automatic run(input int ticks);
    for (int i = 0; i < ticks; i++) begin
      @(negedge clk);
      check_tick();
    end
  endtask

  task automatic run_to_last();
    do begin
      @(negedge clk);
      check_tick();
    end while (mk != mn - 1);
  endtask

  initial begin
    int s0;
    repeat (3) @(negedge clk);
    // R8: reset state
    check(a_clk == 1'b1, "R8 A in reset", a_clk, 1);
    check(b_clk_n == 1'b1, "R8 /B in reset", b_clk_n, 1);
    check(phase == 2'd0, "R8 phase in reset", phase, 0);
    check(cyc_start == 1'b0, "R8 strobe in reset", cyc_start, 0);
    rst = 1'b0;
    run(3 * 18);
    // R5: change select mid-cycle, running cycle keeps its length
    run(5);
    len_sel = 2'b01;
    s0 = strobes;
    run(18 - 6);
    check(strobes == s0, "R5 no early wrap", strobes, s0);
    run(1);
    check(strobes == s0 + 1, "R5 wrap at old length", strobes, s0 + 1);
    run(4 * 14);
    // select change on the tick just before a wrap
    run_to_last();
    len_sel = 2'b10;
    run(5 * 12);
    run_to_last();
    len_sel = 2'b11;
    run(3 * 18);
    // every code, including mid-cycle toggling
    for (int c = 0; c < 4; c++) begin
      run(3);
      len_sel = 2'(c);
      run(2 * 18 + 7);
    end
    // R8: reset in mid-cycle, then resume
    run(4);
    rst = 1'b1;
    len_sel = 2'b01;
    run(2);
    check(a_clk == 1'b1 && cyc_start == 1'b0, "R8 mid-cycle reset", {a_clk, cyc_start}, 2);
    rst = 1'b0;
    run(1);
    check(mk == 1, "R8 resume at k=1", mk, 1);
    run(4 * 14);
    len_sel = 2'b00;
    run(3 * 18);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_checks++;
      n_bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end

endmodule